// File: doc/BRIEF.md
# Prescaled Dual-Mode PWM Channel

This block generates one pulse-width-modulated output from a fast reference clock. A programmable divider slows the clock by any whole ratio from 1 to 4096. Each divider tick advances a 16-bit up counter, which returns to zero at the end of every period. The output is active while the count is below a programmable duration and inactive for the rest of the period. A polarity bit chooses whether "active" means a high or a low level.

In continuous (cycle) mode the waveform repeats for as long as the channel is enabled. In one-shot (pulse) mode the channel rests at the inactive level until software arms it. It then emits exactly one period, disarms itself and returns to rest. Software writes the period and duration at any time. The counter picks up new values only at a period boundary, so a half-finished period is never cut short or stretched. A small write port (enable, address, data) loads the control, divider, period and duration fields. Clearing the enable bit stops the channel at once.

The sequencer has four named states:
- IDLE: the channel is disabled.
- HOLD: pulse mode, armed or resting, with the output inactive.
- RUN: continuous counting.
- PULSE: the one armed period.

The transitions are:
- IDLE to RUN: enable set with cycle mode selected.
- IDLE to HOLD: enable set with pulse mode selected.
- HOLD to PULSE: the start flag is armed.
- HOLD to RUN: the mode is switched to cycle.
- RUN to HOLD: pulse mode is selected; the change happens at the period boundary.
- PULSE to HOLD: the armed period ends.
- Any state to IDLE: enable is cleared.

Top module: `pwm_prescaled_channel`

## Requirements
- R1: After reset, `pwm_out` is 0, `pulse_armed` is 0 and the channel is disabled.
- R2: The divider field sits at address 1, bits [11:0]. With field value N, every counter value lasts exactly N+1 clock cycles, so ratios run from 1 to 4096. A change of N takes effect on the next tick decision.
- R3: The control word sits at address 0. Bit 0 enables the channel and bit 1 selects the mode (0 cycle, 1 pulse). In cycle mode with period P (address 2) and duration D (address 3), the count runs 0 to P-1 and then wraps to 0. The output is active at the start of every period and stays active while count < D.
- R4: A duration of 0 gives a constantly inactive output, and a duration of P or more gives a constantly active output.
- R5: Control bit 2 set makes the active level low and the inactive level high. With the bit clear, the active level is high.
- R6: Period and duration writes made in the middle of a period leave that period unchanged. They apply from the next period start, or from the moment counting begins.
- R7: Pulse mode is armed by a control write that has bits 0, 1 and 3 all set, and `pulse_armed` rises on that write. Exactly one period is then emitted. `pulse_armed` falls when that period ends, and the output holds the inactive level while armed-and-waiting and afterwards.
- R8: A control write that clears bit 0 drives the output to the inactive level in the very next cycle. The same write clears the divider and counter, so a later enable starts a fresh period from count 0 one cycle after the enabling write.
- R9: A period value of 0 behaves as 1: the count holds at 0, and any nonzero duration gives a constantly active output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 divider, 2 period, 3 duration |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | Modulated output |
| pulse_armed | output | 1 | One-shot armed flag, self-clearing |

## Verification
The assertions assume that the write port carries only the four defined addresses. They also assume that a write with the start bit set is never issued in the same cycle as a disabling write. The bench respects both: it issues one write at a time through a single task, and it always clears enable in a write of its own before reprogramming the channel. The assertions also assume that an enable drop may coincide with any counter state. The bench therefore disables the channel in the middle of an active run as well as from rest.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_RUN   = 2'd2,
        ST_PULSE = 2'd3
    } pwm_state_e;

    localparam logic [1:0] ADR_CTRL   = 2'd0;
    localparam logic [1:0] ADR_DIV    = 2'd1;
    localparam logic [1:0] ADR_PERIOD = 2'd2;
    localparam logic [1:0] ADR_DUTY   = 2'd3;

    localparam int CTL_EN    = 0;
    localparam int CTL_MODE  = 1;
    localparam int CTL_POL   = 2;
    localparam int CTL_START = 3;

endpackage

// File: rtl/pwmch_regs.sv
module pwmch_regs
    import pwmch_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pulse_done,
    output logic              en_q,
    output logic              mode_q,
    output logic              pol_q,
    output logic              start_q,
    output logic [PRE_W-1:0]  div_q,
    output logic [CNT_W-1:0]  period_q,
    output logic [CNT_W-1:0]  duty_q
);

    logic arm;

    always_comb begin
        arm = wr_en && (wr_addr == ADR_CTRL) && wr_data[CTL_START]
              && wr_data[CTL_EN] && wr_data[CTL_MODE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            mode_q   <= 1'b0;
            pol_q    <= 1'b0;
            div_q    <= '0;
            period_q <= '0;
            duty_q   <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADR_CTRL: begin
                    en_q   <= wr_data[CTL_EN];
                    mode_q <= wr_data[CTL_MODE];
                    pol_q  <= wr_data[CTL_POL];
                end
                ADR_DIV:    div_q    <= wr_data[PRE_W-1:0];
                ADR_PERIOD: period_q <= wr_data[CNT_W-1:0];
                ADR_DUTY:   duty_q   <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else if (arm) begin
            start_q <= 1'b1;
        end else if (pulse_done || !en_q) begin
            start_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pwmch_prescale.sv
module pwmch_prescale #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);

    logic [PRE_W-1:0] pre_q;

    always_comb begin
        tick = !clr && (pre_q >= div);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwmch_seq.sv
module pwmch_seq
    import pwmch_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mode_pulse,
    input  logic             start_req,
    input  logic             tick,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_duty,
    output pwm_state_e       state_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] sh_period,
    output logic [CNT_W-1:0] sh_duty,
    output logic             counting,
    output logic             pulse_done
);

    pwm_state_e       state_d;
    logic [CNT_W-1:0] last;
    logic             wrap;
    logic             entering;
    logic             load;

    always_comb begin
        last     = (sh_period == '0) ? '0 : sh_period - 1'b1;
        counting = (state_q == ST_RUN) || (state_q == ST_PULSE);
        wrap     = counting && tick && (cnt_q >= last);
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en) state_d = mode_pulse ? ST_HOLD : ST_RUN;
            end
            ST_HOLD: begin
                if (!en)             state_d = ST_IDLE;
                else if (!mode_pulse) state_d = ST_RUN;
                else if (start_req)   state_d = ST_PULSE;
            end
            ST_RUN: begin
                if (!en)                     state_d = ST_IDLE;
                else if (wrap && mode_pulse) state_d = ST_HOLD;
            end
            ST_PULSE: begin
                if (!en)       state_d = ST_IDLE;
                else if (wrap) state_d = ST_HOLD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs of the sequencer: boundary events and shadow loads
    always_comb begin
        entering   = !counting && ((state_d == ST_RUN) || (state_d == ST_PULSE));
        load       = entering || (wrap && en);
        pulse_done = (state_q == ST_PULSE) && wrap && en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            sh_period <= '0;
            sh_duty   <= '0;
        end else begin
            if (load) begin
                sh_period <= cfg_period;
                sh_duty   <= cfg_duty;
            end
            if ((state_d == ST_IDLE) || (state_d == ST_HOLD) || entering || wrap) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_prescaled_channel.sv
module pwm_prescaled_channel
    import pwmch_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out,
    output logic              pulse_armed
);

    logic             en_q;
    logic             mode_q;
    logic             pol_q;
    logic             start_q;
    logic [PRE_W-1:0] div_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] duty_q;
    logic             tick;
    logic             counting;
    logic             pulse_done;
    pwm_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] sh_period;
    logic [CNT_W-1:0] sh_duty;
    logic             active;

    pwmch_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pulse_done (pulse_done),
        .en_q       (en_q),
        .mode_q     (mode_q),
        .pol_q      (pol_q),
        .start_q    (start_q),
        .div_q      (div_q),
        .period_q   (period_q),
        .duty_q     (duty_q)
    );

    pwmch_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!counting || !en_q),
        .div   (div_q),
        .tick  (tick)
    );

    pwmch_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .mode_pulse (mode_q),
        .start_req  (start_q),
        .tick       (tick),
        .cfg_period (period_q),
        .cfg_duty   (duty_q),
        .state_q    (state_q),
        .cnt_q      (cnt_q),
        .sh_period  (sh_period),
        .sh_duty    (sh_duty),
        .counting   (counting),
        .pulse_done (pulse_done)
    );

    // output process
    always_comb begin
        active      = en_q && counting && (cnt_q < sh_duty);
        pwm_out     = active ^ pol_q;
        pulse_armed = start_q;
    end

endmodule

// File: rtl/pwmch_checker.sv
module pwmch_checker
    import pwmch_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_q,
    input logic             pol_q,
    input logic             tick,
    input logic             counting,
    input pwm_state_e       state_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] sh_period,
    input logic [CNT_W-1:0] sh_duty,
    input logic             pwm_out,
    input logic             pulse_armed
);

    logic [CNT_W-1:0] chk_last;
    always_comb chk_last = (sh_period <= 1) ? '0 : sh_period - 1'b1;

    AST_OFF_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> pwm_out == pol_q); // R8

    AST_HOLD_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HOLD |-> pwm_out == pol_q); // R7

    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        sh_duty == '0 |-> pwm_out == pol_q); // R4

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        counting |-> cnt_q <= chk_last); // R9

    AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !tick) |=> ($stable(sh_period) && $stable(sh_duty))); // R6

    AST_ARM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && en_q && tick && cnt_q == chk_last) |=> !pulse_armed); // R7

    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && counting && cnt_q == '0 && sh_duty != '0) |-> pwm_out != pol_q); // R3

endmodule

bind pwm_prescaled_channel pwmch_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_q        (en_q),
    .pol_q       (pol_q),
    .tick        (tick),
    .counting    (counting),
    .state_q     (state_q),
    .cnt_q       (cnt_q),
    .sh_period   (sh_period),
    .sh_duty     (sh_duty),
    .pwm_out     (pwm_out),
    .pulse_armed (pulse_armed)
);

// File: tb/test_pwm_prescaled_channel.sv
`timescale 1ns/1ps
module test_pwm_prescaled_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pwm_out;
    logic        pulse_armed;

    int  n_checks = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    pwm_prescaled_channel i_pwm_prescaled_channel (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .pwm_out     (pwm_out),
        .pulse_armed (pulse_armed)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic restart(input int pre, input int per, input int duty, input int ctrl);
        wr(2'd0, 16'd0);
        wr(2'd1, 16'(pre));
        wr(2'd2, 16'(per));
        wr(2'd3, 16'(duty));
        wr(2'd0, 16'(ctrl));
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (pwm_out == lvl && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // wait until a fresh active run begins (sampled at a negedge)
    task automatic sync_active(input logic act);
        int g = 0;
        while (pwm_out == act && g < 20000) begin g++; @(negedge clk); end
        while (pwm_out != act && g < 40000) begin g++; @(negedge clk); end
    endtask

    task automatic measure(input logic act, output int a, output int i);
        sync_active(act);
        run_len(act, a);
        run_len(!act, i);
    endtask

    task automatic count_level(input int n, input logic lvl, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out == lvl) c++;
        end
    endtask

    task automatic t_reset;
        check("R1", "pwm_out after reset", int'(pwm_out), 0);
        check("R1", "pulse_armed after reset", int'(pulse_armed), 0);
    endtask

    task automatic t_cycle_basic;
        int a, i;
        restart(0, 10, 4, 16'h1);
        measure(1'b1, a, i);
        check("R3", "active run P10 D4", a, 4);
        check("R3", "inactive run P10 D4", i, 6);
    endtask

    task automatic t_prescale;
        int a, i;
        wr(2'd1, 16'd2);
        measure(1'b1, a, i);
        check("R2", "active run div 3", a, 12);
        check("R2", "inactive run div 3", i, 18);
        restart(4095, 2, 1, 16'h1);
        measure(1'b1, a, i);
        check("R2", "active run div 4096", a, 4096);
        check("R2", "inactive run div 4096", i, 4096);
    endtask

    task automatic t_shadow;
        int a, i, a2, i2;
        restart(0, 10, 4, 16'h1);
        sync_active(1'b1);
        wr(2'd3, 16'd7);
        run_len(1'b1, a);
        a += 2;
        run_len(1'b0, i);
        check("R6", "duty write mid-period keeps active run", a, 4);
        check("R6", "inactive run of current period", i, 6);
        run_len(1'b1, a2);
        run_len(1'b0, i2);
        check("R6", "next period uses new duty", a2, 7);
        check("R6", "next period inactive", i2, 3);
    endtask

    task automatic t_polarity;
        int a, i;
        restart(0, 10, 3, 16'h5);
        measure(1'b0, a, i);
        check("R5", "active-low run length", a, 3);
        check("R5", "inactive-high run length", i, 7);
    endtask

    task automatic t_disable;
        int a;
        restart(0, 10, 4, 16'h1);
        sync_active(1'b1);
        wr(2'd0, 16'd0);
        check("R8", "output inactive right after disable", int'(pwm_out), 0);
        repeat (7) @(negedge clk);
        check("R8", "output stays inactive while disabled", int'(pwm_out), 0);
        wr(2'd0, 16'h1);
        check("R8", "output before restart edge", int'(pwm_out), 0);
        @(negedge clk);
        check("R8", "active one cycle after enable", int'(pwm_out), 1);
        run_len(1'b1, a);
        check("R8", "restart gives full active run", a, 4);
    endtask

    task automatic t_extremes;
        int c;
        restart(0, 10, 0, 16'h1);
        count_level(40, 1'b0, c);
        check("R4", "duty 0 always inactive", c, 40);
        restart(0, 10, 10, 16'h1);
        count_level(40, 1'b1, c);
        check("R4", "duty equal period always active", c, 40);
        restart(0, 10, 15, 16'h1);
        count_level(40, 1'b1, c);
        check("R4", "duty above period always active", c, 40);
        restart(0, 0, 1, 16'h1);
        count_level(40, 1'b1, c);
        check("R9", "period 0 duty 1 always active", c, 40);
    endtask

    task automatic t_pulse;
        int c;
        restart(1, 6, 2, 16'h3);
        repeat (20) @(negedge clk);
        check("R7", "pulse mode rests inactive", int'(pwm_out), 0);
        check("R7", "not armed before start", int'(pulse_armed), 0);
        wr(2'd0, 16'hB);
        check("R7", "armed after start write", int'(pulse_armed), 1);
        count_level(40, 1'b1, c);
        check("R7", "single positive pulse width", c, 4);
        check("R7", "armed clears after pulse", int'(pulse_armed), 0);
        check("R7", "inactive after pulse", int'(pwm_out), 0);
        wr(2'd0, 16'h7);
        repeat (5) @(negedge clk);
        check("R7", "negative pulse idle level high", int'(pwm_out), 1);
        wr(2'd0, 16'hF);
        count_level(40, 1'b0, c);
        check("R7", "single negative pulse width", c, 4);
        check("R7", "armed clears after negative pulse", int'(pulse_armed), 0);
        check("R7", "high after negative pulse", int'(pwm_out), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cycle_basic();
        t_prescale();
        t_shadow();
        t_polarity();
        t_disable();
        t_extremes();
        t_pulse();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule